// File: doc/BRIEF.md
# Flash Status Polling Bit Generator

This block forms the status bits that a host sees when it reads a flash memory during an embedded program or erase. The surrounding controller supplies the current operation mode, the set of blocks being erased, the block index of the current read address, bit 7 of the data being programmed, and single-cycle events: operation start, failure, reset command and erase arming. The block answers with a data-polling bit, a toggle bit that flips on every read, an error flag, an erase-timer bit and a per-block toggle bit. The per-block toggle bit tells the host which blocks are being erased and which block failed.

Two timers also live here. The first holds off the start of an erase for a set number of cycles after the last block-erase command. The second holds array reads as not ready for a while after a reset command aborts an erase. The `statusSel` output tells the host whether the current read should return status bits or array data.

Mode encoding on `opMode`: 0 = idle, 1 = program, 2 = erase, 3 = erase suspended.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `errBit`=0, `timerBit`=1, `arrayReady`=1, `statusSel`=0, and the toggle state is 0.
- R2: With `opMode`=1 (program), `statusSel`=1, `pollBit` is the inverse of `dataBit7`, and `blkToggleBit`=1.
- R3: The toggle state is cleared by `opStart` and inverts once for each rising edge of `rdStrobe`. The new value appears in the cycle after the edge is sampled. `toggleBit` shows it in program mode, in erase mode, and in idle mode while `errBit`=1. A clear takes precedence over a flip.
- R4: With `opMode`=2 (erase), `pollBit`=0 and `statusSel`=1. `blkToggleBit` equals the toggle state when `eraseMask[readBlk]`=1 and reads 1 otherwise, so with an all-ones mask it toggles for every block.
- R5: With `opMode`=3 (suspended), a read of a block whose mask bit is 1 gives `statusSel`=1, `pollBit`=1, `toggleBit`=1, and `blkToggleBit` equal to the toggle state. A read of a block whose mask bit is 0 gives `statusSel`=0 (array data).
- R6: `failEvt` sets `errBit` in the next cycle and records `failBlk`. `errBit` then holds until `resetCmd` or `opStart`. If `failEvt` and `resetCmd` coincide, the set wins.
- R7: In idle mode with `errBit`=1: `statusSel`=1, `pollBit`=`dataBit7`, and `blkToggleBit` equals the toggle state when `readBlk` is the recorded failed block and 1 otherwise. In idle mode with `errBit`=0, `statusSel`=0.
- R8: `eraseArm` drives `timerBit` low for exactly `ERASE_WAIT` cycles after its last pulse. Arming again restarts the full wait.
- R9: A `resetCmd` while `opMode` is 2 or 3 drives `arrayReady` low for exactly `RESET_WAIT` cycles. A `resetCmd` in idle or program mode leaves `arrayReady` at 1.
- R10: An operation that starts with `opStart` and has no `failEvt` ends with `errBit`=0, even when an earlier failure had set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opMode | input | 2 | Operation mode: 0 idle, 1 program, 2 erase, 3 suspended |
| opStart | input | 1 | Pulse: a program or erase begins |
| eraseMask | input | NUM_BLK | One bit per block under erase |
| readBlk | input | BLK_W | Block index of the current read address |
| dataBit7 | input | 1 | Bit 7 of the data being programmed |
| failEvt | input | 1 | Pulse: the operation failed |
| failBlk | input | BLK_W | Block index of the failure |
| rdStrobe | input | 1 | Read strobe, active high |
| resetCmd | input | 1 | Pulse: read/reset command decoded |
| eraseArm | input | 1 | Pulse: a block-erase command was accepted |
| statusSel | output | 1 | 1: read returns status bits, 0: array data |
| pollBit | output | 1 | Data-polling bit |
| toggleBit | output | 1 | Read toggle bit |
| errBit | output | 1 | Failure flag |
| timerBit | output | 1 | 0 while the erase start wait runs |
| blkToggleBit | output | 1 | Block-selective toggle bit |
| arrayReady | output | 1 | 0 during the wait after a reset that aborts an erase |

## Verification
On every cycle the assertions check the following: the polling bit stays low during erase, the suspended-block values are forced, the error flag sets, holds and clears as specified, each read edge inverts the toggle bit in program mode, and each arming or aborting reset starts a timer. Some behaviour can only be shown by the bench's scenarios. This covers the exact length of both waits, re-arming that restarts the erase wait, the block-selective toggle across every mask and block combination, and the failed-block toggle after the operation ends.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_SUSP  = 2'd3
  } opMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic togFlip;   // a read edge was seen this cycle
    logic togClear;  // operation start: reset toggle state
    logic errFlag;   // failure flag currently set
  } ctlStrobe_t;

endpackage

// File: rtl/fsp_wait_timer.sv
module fsp_wait_timer #(
  parameter int WAIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic idle
);
  localparam int CW = $clog2(WAIT + 1);
  localparam logic [CW-1:0] LOADV = CW'(WAIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOADV;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int BLK_W      = 2,
  parameter int ERASE_WAIT = 12500,
  parameter int RESET_WAIT = 1250
) (
  input  logic             clk,
  input  logic             rstN,
  input  opMode_e          mode,
  input  logic             opStart,
  input  logic             failEvt,
  input  logic [BLK_W-1:0] failBlk,
  input  logic             rdStrobe,
  input  logic             resetCmd,
  input  logic             eraseArm,
  output ctlStrobe_t       strobe,
  output logic [BLK_W-1:0] errBlk,
  output logic             timerIdle,
  output logic             readyIdle
);
  logic rdQ;
  logic errQ;
  logic [BLK_W-1:0] errBlkQ;
  logic abortLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= 1'b0;
    end else begin
      rdQ <= rdStrobe;
    end
  end

  // failure flag: set wins over any clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errQ    <= 1'b0;
      errBlkQ <= '0;
    end else if (failEvt) begin
      errQ    <= 1'b1;
      errBlkQ <= failBlk;
    end else if (resetCmd || opStart) begin
      errQ <= 1'b0;
    end
  end

  assign abortLoad = resetCmd && ((mode == OP_ERASE) || (mode == OP_SUSP));

  fsp_wait_timer #(.WAIT(ERASE_WAIT)) i_eraseTimer (
    .clk  (clk),
    .rstN (rstN),
    .load (eraseArm),
    .idle (timerIdle)
  );

  fsp_wait_timer #(.WAIT(RESET_WAIT)) i_abortTimer (
    .clk  (clk),
    .rstN (rstN),
    .load (abortLoad),
    .idle (readyIdle)
  );

  always_comb begin
    strobe.togFlip  = rdStrobe && !rdQ;
    strobe.togClear = opStart;
    strobe.errFlag  = errQ;
  end

  assign errBlk = errBlkQ;
endmodule

// File: rtl/fsp_datapath.sv
module fsp_datapath
  import fsp_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int BLK_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  opMode_e            mode,
  input  logic [NUM_BLK-1:0] eraseMask,
  input  logic [BLK_W-1:0]   readBlk,
  input  logic               dataBit7,
  input  ctlStrobe_t         strobe,
  input  logic [BLK_W-1:0]   errBlk,
  output logic               statusSel,
  output logic               pollBit,
  output logic               toggleBit,
  output logic               blkToggleBit
);
  logic togQ;
  logic inSet;
  logic onErrBlk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      togQ <= 1'b0;
    end else if (strobe.togClear) begin
      togQ <= 1'b0;
    end else if (strobe.togFlip) begin
      togQ <= ~togQ;
    end
  end

  assign inSet    = eraseMask[readBlk];
  assign onErrBlk = (readBlk == errBlk);

  always_comb begin
    statusSel    = 1'b0;
    pollBit      = dataBit7;
    toggleBit    = 1'b0;
    blkToggleBit = 1'b0;
    unique case (mode)
      OP_IDLE: begin
        statusSel    = strobe.errFlag;
        toggleBit    = strobe.errFlag & togQ;
        blkToggleBit = strobe.errFlag & (onErrBlk ? togQ : 1'b1);
      end
      OP_PROG: begin
        statusSel    = 1'b1;
        pollBit      = ~dataBit7;
        toggleBit    = togQ;
        blkToggleBit = 1'b1;
      end
      OP_ERASE: begin
        statusSel    = 1'b1;
        pollBit      = 1'b0;
        toggleBit    = togQ;
        blkToggleBit = inSet ? togQ : 1'b1;
      end
      OP_SUSP: begin
        statusSel    = inSet;
        pollBit      = inSet | dataBit7;
        toggleBit    = inSet;
        blkToggleBit = inSet & togQ;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsp_pkg::*;
#(
  parameter int NUM_BLK    = 4,
  parameter int ERASE_WAIT = 12500,
  parameter int RESET_WAIT = 1250,
  localparam int BLK_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         opMode,
  input  logic               opStart,
  input  logic [NUM_BLK-1:0] eraseMask,
  input  logic [BLK_W-1:0]   readBlk,
  input  logic               dataBit7,
  input  logic               failEvt,
  input  logic [BLK_W-1:0]   failBlk,
  input  logic               rdStrobe,
  input  logic               resetCmd,
  input  logic               eraseArm,
  output logic               statusSel,
  output logic               pollBit,
  output logic               toggleBit,
  output logic               errBit,
  output logic               timerBit,
  output logic               blkToggleBit,
  output logic               arrayReady
);
  opMode_e          mode;
  ctlStrobe_t       strobe;
  logic [BLK_W-1:0] errBlk;

  assign mode = opMode_e'(opMode);

  fsp_ctrl #(
    .BLK_W      (BLK_W),
    .ERASE_WAIT (ERASE_WAIT),
    .RESET_WAIT (RESET_WAIT)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .opStart   (opStart),
    .failEvt   (failEvt),
    .failBlk   (failBlk),
    .rdStrobe  (rdStrobe),
    .resetCmd  (resetCmd),
    .eraseArm  (eraseArm),
    .strobe    (strobe),
    .errBlk    (errBlk),
    .timerIdle (timerBit),
    .readyIdle (arrayReady)
  );

  fsp_datapath #(
    .NUM_BLK (NUM_BLK),
    .BLK_W   (BLK_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .mode         (mode),
    .eraseMask    (eraseMask),
    .readBlk      (readBlk),
    .dataBit7     (dataBit7),
    .strobe       (strobe),
    .errBlk       (errBlk),
    .statusSel    (statusSel),
    .pollBit      (pollBit),
    .toggleBit    (toggleBit),
    .blkToggleBit (blkToggleBit)
  );

  assign errBit = strobe.errFlag;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int NUM_BLK = 4,
  localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         opMode,
  input logic               opStart,
  input logic [NUM_BLK-1:0] eraseMask,
  input logic [BLK_W-1:0]   readBlk,
  input logic               failEvt,
  input logic               rdStrobe,
  input logic               resetCmd,
  input logic               eraseArm,
  input logic               statusSel,
  input logic               pollBit,
  input logic               toggleBit,
  input logic               errBit,
  input logic               timerBit,
  input logic               arrayReady
);
  p_erase_poll_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 2'd2) |-> (!pollBit && statusSel));

  p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdStrobe) && !opStart && opMode == 2'd1)
      |=> (opMode != 2'd1 || toggleBit != $past(toggleBit)));

  p_susp_forced_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 2'd3 && eraseMask[readBlk]) |-> (statusSel && pollBit && toggleBit));

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    failEvt |=> errBit);

  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errBit && !resetCmd && !opStart) |=> errBit);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && !failEvt) |=> !errBit);

  p_timer_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    eraseArm |=> !timerBit);

  p_not_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resetCmd && opMode[1]) |=> !arrayReady);
endmodule

bind flash_status_gen fsp_checker #(.NUM_BLK(NUM_BLK)) i_fspChecker (
  .clk        (clk),
  .rstN       (rstN),
  .opMode     (opMode),
  .opStart    (opStart),
  .eraseMask  (eraseMask),
  .readBlk    (readBlk),
  .failEvt    (failEvt),
  .rdStrobe   (rdStrobe),
  .resetCmd   (resetCmd),
  .eraseArm   (eraseArm),
  .statusSel  (statusSel),
  .pollBit    (pollBit),
  .toggleBit  (toggleBit),
  .errBit     (errBit),
  .timerBit   (timerBit),
  .arrayReady (arrayReady)
);

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
  localparam int NB = 4;
  localparam int EW = 20;
  localparam int RW = 6;

  // observation vector: {sel, poll, tog, err, timer, blkTog, ready}
  localparam logic [6:0] M_SEL = 7'b1000000;
  localparam logic [6:0] M_PL  = 7'b0100000;
  localparam logic [6:0] M_TG  = 7'b0010000;
  localparam logic [6:0] M_ER  = 7'b0001000;
  localparam logic [6:0] M_TM  = 7'b0000100;
  localparam logic [6:0] M_BT  = 7'b0000010;
  localparam logic [6:0] M_RD  = 7'b0000001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] opMode = 2'd0;
  logic opStart = 1'b0;
  logic [NB-1:0] eraseMask = '0;
  logic [1:0] readBlk = '0;
  logic dataBit7 = 1'b0;
  logic failEvt = 1'b0;
  logic [1:0] failBlk = '0;
  logic rdStrobe = 1'b0;
  logic resetCmd = 1'b0;
  logic eraseArm = 1'b0;
  logic statusSel, pollBit, toggleBit, errBit, timerBit, blkToggleBit, arrayReady;

  int nChk = 0;
  int nBad = 0;
  logic par = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_status_gen #(.NUM_BLK(NB), .ERASE_WAIT(EW), .RESET_WAIT(RW)) i_flash_status_gen (
    .clk(clk), .rstN(rstN), .opMode(opMode), .opStart(opStart), .eraseMask(eraseMask),
    .readBlk(readBlk), .dataBit7(dataBit7), .failEvt(failEvt), .failBlk(failBlk),
    .rdStrobe(rdStrobe), .resetCmd(resetCmd), .eraseArm(eraseArm),
    .statusSel(statusSel), .pollBit(pollBit), .toggleBit(toggleBit), .errBit(errBit),
    .timerBit(timerBit), .blkToggleBit(blkToggleBit), .arrayReady(arrayReady)
  );

  function automatic logic [6:0] obs();
    return {statusSel, pollBit, toggleBit, errBit, timerBit, blkToggleBit, arrayReady};
  endfunction

  task automatic chk(input string tag, input logic [6:0] exp, input logic [6:0] msk);
    logic [6:0] act = obs();
    nChk++;
    if ((act & msk) !== (exp & msk)) begin
      nBad++;
      $display("FAIL %s actual=%b expected=%b care=%b", tag, act & msk, exp & msk, msk);
    end
  endtask

  task automatic chkN(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doRead();
    rdStrobe = 1'b1;
    tick();
    rdStrobe = 1'b0;
    tick();
    par = ~par;
  endtask

  task automatic pulseStart();
    opStart = 1'b1; tick(); opStart = 1'b0; par = 1'b0;
  endtask

  task automatic pulseFail(input logic [1:0] b);
    failBlk = b; failEvt = 1'b1; tick(); failEvt = 1'b0;
  endtask

  task automatic pulseReset();
    resetCmd = 1'b1; tick(); resetCmd = 1'b0;
  endtask

  task automatic pulseArm();
    eraseArm = 1'b1; tick(); eraseArm = 1'b0;
  endtask

  function automatic int lowTimer();
    return timerBit ? 0 : 1;
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1: reset state
    chk("R1 reset", 7'b0000101, M_SEL | M_ER | M_TM | M_RD | M_TG);

    // R2/R3: program, both data polarities, toggle sequence
    opMode = 2'd1;
    pulseStart();
    chk("R3 toggle cleared at start", {4'b1000, 3'b0}, M_TG);
    for (int d = 0; d < 2; d++) begin
      dataBit7 = d[0];
      for (int k = 0; k < 4; k++) begin
        doRead();
        chk("R2 R3 program", {1'b1, ~d[0], par, 2'b00, 1'b1, 1'b0}, M_SEL | M_PL | M_TG | M_BT);
      end
    end

    // R4: erase sweep over every nonzero mask and block
    opMode = 2'd2;
    for (int m = 1; m < 16; m++) begin
      eraseMask = m[NB-1:0];
      pulseStart();
      for (int b = 0; b < NB; b++) begin
        readBlk = b[1:0];
        doRead();
        chk("R4 erase", {1'b1, 1'b0, par, 2'b00, (m[b] ? par : 1'b1), 1'b0},
            M_SEL | M_PL | M_TG | M_BT);
      end
    end

    // R5: suspended, inside and outside the erasing set
    opMode = 2'd3;
    dataBit7 = 1'b0;
    for (int m = 0; m < 16; m++) begin
      eraseMask = m[NB-1:0];
      for (int b = 0; b < NB; b++) begin
        readBlk = b[1:0];
        doRead();
        if (m[b])
          chk("R5 suspend in set", {3'b111, 2'b00, par, 1'b0}, M_SEL | M_PL | M_TG | M_BT);
        else
          chk("R5 suspend outside set", 7'b0, M_SEL);
      end
    end

    // R6/R7: failure during erase, then idle with error
    opMode = 2'd2;
    eraseMask = 4'b0100;
    pulseStart();
    pulseFail(2'd2);
    chk("R6 error set", 7'b0001000, M_ER);
    opMode = 2'd0;
    dataBit7 = 1'b1;
    for (int b = 0; b < NB; b++) begin
      readBlk = b[1:0];
      doRead();
      chk("R6 R7 idle after failure", {1'b1, 1'b1, par, 1'b1, 1'b0, (b == 2 ? par : 1'b1), 1'b0},
          M_SEL | M_PL | M_TG | M_ER | M_BT);
    end
    pulseReset();
    chk("R6 reset clears error", 7'b0000001, M_ER | M_SEL | M_RD);
    chk("R9 idle reset keeps ready", 7'b0000001, M_RD);

    // R6: set wins over simultaneous reset
    failBlk = 2'd1;
    failEvt = 1'b1;
    resetCmd = 1'b1;
    tick();
    failEvt = 1'b0;
    resetCmd = 1'b0;
    chk("R6 set wins", 7'b0001000, M_ER);

    // R10: new operation without failure clears error
    opMode = 2'd1;
    pulseStart();
    opMode = 2'd0;
    tick();
    chk("R10 success clears error", 7'b0, M_ER | M_SEL);

    // R8: erase start wait length, and restart on re-arm
    pulseArm();
    cnt = 0;
    while (!timerBit && cnt < 1000) begin cnt++; tick(); end
    chkN("R8 erase wait length", cnt, EW);
    pulseArm();
    repeat (10) tick();
    pulseArm();
    cnt = 0;
    while (!timerBit && cnt < 1000) begin cnt++; tick(); end
    chkN("R8 re-arm restarts wait", cnt, EW);

    // R9: reset during erase blocks array reads for the wait
    opMode = 2'd2;
    pulseReset();
    cnt = 0;
    while (!arrayReady && cnt < 1000) begin cnt++; tick(); end
    chkN("R9 abort wait length", cnt, RW);
    opMode = 2'd3;
    pulseReset();
    cnt = 0;
    while (!arrayReady && cnt < 1000) begin cnt++; tick(); end
    chkN("R9 abort wait in suspend", cnt, RW);
    opMode = 2'd1;
    pulseReset();
    chk("R9 program reset keeps ready", 7'b0000001, M_RD);
    cnt = lowTimer();
    chkN("R8 timer idle at end", cnt, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule